// File: doc/BRIEF.md
# Twenty-Step Repeating Sequence Counter

This block is a synchronous 4-bit counter that repeats a fixed sequence of 20 states. Starting from 0 it climbs one step at a time to 15. It then jumps back to 12, climbs to 15 a second time, and finally wraps to 0 to begin the next period. The value 15 is therefore reached twice in every period. A one-bit pass register records which visit to 15 is in progress. On the first visit the counter loads the re-entry value through its parallel load path. On the second visit it clears to zero.

The core is a plain binary counter with synchronous clear and synchronous load. A small decoder turns the terminal-count condition and the pass bit into load, clear, increment and toggle controls. A count enable freezes the whole state when low. A period-start output is high while the counter sits at the top of a period, which lets downstream logic align to each 20-cycle frame.

Top module: `seq20_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes 0 and the pass bit is cleared, so `period_start` is high after reset.
- R2: With `cnt_en` high and the count below 15, each rising edge adds one to the count. Bit 0 of `count` is the least significant bit and bit 3 is the most significant.
- R3: With `cnt_en` high, the first arrival at 15 in a period is followed by 12.
- R4: With `cnt_en` high, the second arrival at 15 in a period is followed by 0.
- R5: With `cnt_en` held high, the output runs 0,1,…,15,12,13,14,15 and repeats, so one period lasts exactly 20 clock cycles.
- R6: With `cnt_en` low, neither the count nor the pass bit changes. After the pause, the sequence resumes exactly where it stopped, including at either visit to 15.
- R7: `period_start` is high exactly when the count is 0 at the top of a period. With enable held high it is high for one cycle in every 20.
- R8: A reset applied during the second pass (12 to 15) restarts the period from the top, so the next arrival at 15 is followed by 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable; low holds all state |
| count | output | 4 | Current sequence value, bit 0 least significant |
| period_start | output | 1 | High while the counter is at the top of a period |

## Verification
The hardest situation to reach from the ports is one where the count alone does not identify the state. The values 12 to 15 occur in both passes, and only the hidden pass bit tells them apart. The bench therefore holds the enable low for several cycles exactly at each of the two visits to 15, then releases it and checks which action follows. It also applies reset in the middle of the second pass to confirm that the pass bit returns to the top-of-period value. A long run with enable driven from a pseudo-random bit stream then mixes pauses into every position, and a behavioural position-in-period model is compared against the outputs on every cycle.

// File: rtl/seq20_pkg.sv
package seq20_pkg;

    localparam int CNT_W = 4;
    localparam int PERIOD_LEN = 20;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_TOP = '1;
    localparam cnt_t CNT_REENTRY = cnt_t'(12);

    // Which visit to the terminal count is in progress.
    typedef enum logic {
        PASS_FULL  = 1'b0,
        PASS_SHORT = 1'b1
    } pass_e;

    // Per-cycle action decided by the control decoder.
    typedef struct packed {
        logic clr;
        logic load;
        logic inc;
        logic flip;
    } step_ctl_t;

    function automatic logic at_terminal(input cnt_t v);
        return v == CNT_TOP;
    endfunction

    function automatic step_ctl_t decode_step(input logic en, input logic term, input pass_e pass);
        step_ctl_t c;
        c.inc  = en;
        c.flip = en && term;
        c.load = en && term && (pass == PASS_FULL);
        c.clr  = en && term && (pass == PASS_SHORT);
        return c;
    endfunction

endpackage

// File: rtl/seq20_bincnt.sv
module seq20_bincnt
    import seq20_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic         inc,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end else if (inc) begin
            q <= q + ONE;
        end
    end

    assign tc = &q;

endmodule

// File: rtl/seq20_pass.sv
module seq20_pass
    import seq20_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flip,
    output pass_e pass
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pass <= PASS_FULL;
        end else if (flip) begin
            pass <= (pass == PASS_FULL) ? PASS_SHORT : PASS_FULL;
        end
    end

endmodule

// File: rtl/seq20_ctrl.sv
module seq20_ctrl
    import seq20_pkg::*;
(
    input  logic      en,
    input  logic      term,
    input  pass_e     pass,
    output step_ctl_t ctl
);

    always_comb begin
        ctl = decode_step(en, term, pass);
    end

endmodule

// File: rtl/seq20_top.sv
module seq20_top
    import seq20_pkg::*;
#(
    parameter cnt_t REENTRY = CNT_REENTRY
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    output logic [CNT_W-1:0] count,
    output logic             period_start
);

    step_ctl_t ctl;
    pass_e     pass_q;
    logic      term;
    cnt_t      cnt_q;

    seq20_ctrl u_ctrl (
        .en   (cnt_en),
        .term (term),
        .pass (pass_q),
        .ctl  (ctl)
    );

    seq20_bincnt #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctl.clr),
        .load (ctl.load),
        .inc  (ctl.inc),
        .din  (REENTRY),
        .q    (cnt_q),
        .tc   (term)
    );

    seq20_pass u_pass (
        .clk  (clk),
        .rst  (rst),
        .flip (ctl.flip),
        .pass (pass_q)
    );

    assign count        = cnt_q;
    assign period_start = (cnt_q == '0) && (pass_q == PASS_FULL);

endmodule

// File: rtl/seq20_chk.sv
module seq20_chk
    import seq20_pkg::*;
#(
    parameter cnt_t REENTRY = CNT_REENTRY
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic [CNT_W-1:0] count,
    input logic             period_start,
    input logic             pass_bit
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (count == '0) && !pass_bit);

    // R2
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_en && (count != CNT_TOP) |=> count == CNT_W'($past(count) + 1'b1));

    // R3
    reentry_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_en && (count == CNT_TOP) && !pass_bit |=> count == REENTRY);

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_en && (count == CNT_TOP) && pass_bit |=> count == '0);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(count) && $stable(pass_bit));

    // R7
    start_zero_chk: assert property (@(posedge clk) disable iff (rst)
        period_start |-> count == '0);

    // R7
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_en && period_start |=> !period_start);

endmodule

bind seq20_top seq20_chk #(.REENTRY(REENTRY)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cnt_en       (cnt_en),
    .count        (count),
    .period_start (period_start),
    .pass_bit     (pass_q)
);

// File: tb/sim_seq20_top.sv
`timescale 1ns/1ps
module sim_seq20_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [3:0] count;
    logic       period_start;

    int errors = 0;
    int checks = 0;
    int pos = 0;          // position inside the 20-step period
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    seq20_top u0 (
        .clk          (clk),
        .rst          (rst),
        .cnt_en       (cnt_en),
        .count        (count),
        .period_start (period_start)
    );

    function automatic int exp_val(input int p);
        return (p < 16) ? p : p - 4;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (pos %0d, cycle %0d)", req, act, exp, pos, cyc);
        end
    endtask

    task automatic step(input bit r, input bit e, input string rtag);
        string tag;
        rst = r;
        cnt_en = e;
        @(posedge clk);
        cyc++;
        if (r) begin
            tag = rtag;
            pos = 0;
        end else if (!e) begin
            tag = "R6";
        end else if (pos == 15) begin
            tag = "R3";
            pos = 16;
        end else if (pos == 19) begin
            tag = "R4";
            pos = 0;
        end else begin
            tag = "R2";
            pos = pos + 1;
        end
        @(negedge clk);
        check(count == 4'(exp_val(pos)), tag, int'(count), exp_val(pos));
        check(period_start == (pos == 0), "R7", int'(period_start), int'(pos == 0));
    endtask

    task automatic run_to(input int target);
        while (pos != target) step(1'b0, 1'b1, "R1");
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int last_start;
        @(negedge clk);
        // R1: reset state
        step(1'b1, 1'b0, "R1");
        step(1'b1, 1'b1, "R1");

        // R5: continuous run, start flags exactly 20 apart
        last_start = 0;
        for (int i = 1; i <= 65; i++) begin
            step(1'b0, 1'b1, "R1");
            if (period_start) begin
                check(i - last_start == 20, "R5", i - last_start, 20);
                last_start = i;
            end
        end

        // R6: pause at first visit to 15, then expect 12
        run_to(15);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b1, "R1");
        check(count == 4'd12, "R6", int'(count), 12);

        // R6: pause at second visit to 15, then expect 0
        run_to(19);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b1, "R1");
        check(count == 4'd0, "R6", int'(count), 0);

        // R8: reset in the second pass, next 15 must load 12
        run_to(17);
        step(1'b1, 1'b1, "R8");
        check(count == 4'd0 && period_start, "R8", int'(count), 0);
        run_to(15);
        step(1'b0, 1'b1, "R1");
        check(count == 4'd12, "R8", int'(count), 12);

        // mixed enable from a pseudo-random stream
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(1'b0, lfsr[0] | lfsr[3], "R1");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule